// File: doc/BRIEF.md
# Row Leader Broadcast Relay

This block models one row of small processor submeshes that share fixed buses without switches. Each submesh has its own column buses. The top-row buses of all submeshes in the row are joined into one shared row-wide bus. The block copies a data word from the leader of one submesh to the leader of every submesh in the row. A leader is the processor in the bottom-right corner of its submesh (last row, last column). Leaders do not share a bus, so every broadcast follows a fixed three-hop route. First the source leader drives its column bus, and the top-row processor of that column latches the word. Next that top-row processor drives the shared row bus, and every top-row processor latches the word. Last, every top-row processor drives its own column bus, and each leader latches the word.

A user selects the source submesh, presents the word and pulses `start_i` for one cycle. The word reaches all leader registers three cycles later. `done_o` then pulses for one cycle. The controller has five states:
- `PH_IDLE`: waits. An accepted start moves it to `PH_UP`.
- `PH_UP`: the source leader drives its column bus. Moves to `PH_ACROSS`.
- `PH_ACROSS`: the source top-row processor drives the shared row bus. Moves to `PH_DOWN`.
- `PH_DOWN`: every top-row processor drives its column bus and the leaders latch. Moves to `PH_FIN`.
- `PH_FIN`: `done_o` is high. Returns to `PH_IDLE`.

Each transition is taken unconditionally after one cycle, except the one out of `PH_IDLE`.

Top module: `row_leader_relay`

## Requirements
- R1: While reset is held and after it is released, every leader register reads zero and `done_o` is low.
- R2: A start is accepted on a rising edge in `PH_IDLE`. The leader registers take the new word on the third rising edge after that edge. `done_o` is high for exactly the one cycle that follows that third edge.
- R3: Every leader register receives the word, including the register of the source submesh. Leader i occupies bits [i*DW +: DW] of `leader_q_o`.
- R4: A start pulse has no effect while a broadcast is in flight. This includes the cycle in which `done_o` is high. It produces no extra `done_o` pulse and changes no leader register.
- R5: A start with a source select of NSUB or more is ignored. No `done_o` pulse follows, and the leader registers keep their values.
- R6: In every cycle each column bus and the shared row bus has at most one active driver.
- R7: Leader registers hold their previous values until the down phase of the next accepted broadcast.
- R8: The states follow the order `PH_IDLE`, `PH_UP`, `PH_ACROSS`, `PH_DOWN`, `PH_FIN`, `PH_IDLE`. Every state except `PH_IDLE` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for one broadcast |
| src_sel_i | input | SELW | Index of the source submesh |
| data_i | input | DW | Word to broadcast, captured with the start |
| leader_q_o | output | NSUB*DW | Leader registers, leader i at [i*DW +: DW] |
| done_o | output | 1 | One-cycle pulse after the leaders latch the word |

## Verification
Broadcasts are started from the first submesh, the last submesh and a middle submesh, so a routing fault that depends on the source index becomes visible. The data words include all ones, all zeros and alternating patterns. Each word differs from the one before it, so a leader that missed an update, or a stuck data bit, shows a mismatch. Starts are also sent in two cases that must be ignored: while the relay is busy (including the done cycle) and with an out-of-range source. Each of these uses a word the design must never output, so a stray acceptance shows up as a wrong value or an extra done pulse. Sampling the leader registers during the up and across phases separates a correct three-hop relay from one that updates the leaders too early.

// File: rtl/relay_pkg.sv
package relay_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_UP     = 3'd1,
        PH_ACROSS = 3'd2,
        PH_DOWN   = 3'd3,
        PH_FIN    = 3'd4
    } phase_t;
endpackage

// File: rtl/relay_fsm.sv
module relay_fsm
    import relay_pkg::*;
#(
    parameter int NSUB = 4,
    parameter int DW   = 16,
    parameter int SELW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [SELW-1:0] src_sel_i,
    input  logic [DW-1:0]   data_i,
    output phase_t          phase_o,
    output logic [SELW-1:0] src_q_o,
    output logic [DW-1:0]   word_q_o,
    output logic            done_o
);
    localparam logic [SELW-1:0] SRC_LIMIT = SELW'(NSUB);

    phase_t state_q, state_d;
    logic   accept;

    assign accept = (state_q == PH_IDLE) && start_i && (src_sel_i < SRC_LIMIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:   if (accept) state_d = PH_UP;
            PH_UP:     state_d = PH_ACROSS;
            PH_ACROSS: state_d = PH_DOWN;
            PH_DOWN:   state_d = PH_FIN;
            PH_FIN:    state_d = PH_IDLE;
            default:   state_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PH_IDLE;
            src_q_o  <= '0;
            word_q_o <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                src_q_o  <= src_sel_i;
                word_q_o <= data_i;
            end
        end
    end

    always_comb begin
        phase_o = state_q;
        done_o  = (state_q == PH_FIN);
    end

    // R8: a broadcast walks the fixed phase order
    assert_up_to_across_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_UP) |=> (state_q == PH_ACROSS));
    assert_across_to_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ACROSS) |=> (state_q == PH_DOWN));
    assert_down_to_fin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DOWN) |=> (state_q == PH_FIN));
    // R4: a start in a busy phase never launches a new up phase
    assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE && start_i) |=> (state_q != PH_UP));
    // R5: an out-of-range source never launches
    assert_bad_source_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && src_sel_i >= SRC_LIMIT) |=> (state_q == PH_IDLE));
endmodule

// File: rtl/submesh_column.sv
module submesh_column
    import relay_pkg::*;
#(
    parameter int DW   = 16,
    parameter int SELW = 3,
    parameter int IDX  = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase_i,
    input  logic [SELW-1:0] src_i,
    input  logic [DW-1:0]   word_i,
    input  logic [DW-1:0]   row_bus_i,
    output logic            row_drv_o,
    output logic [DW-1:0]   top_q_o,
    output logic [DW-1:0]   leader_q_o
);
    localparam logic [SELW-1:0] MY_IDX = SELW'(IDX);

    logic          is_src;
    logic          leader_drv;
    logic          top_drv;
    logic [DW-1:0] col_bus;

    assign is_src     = (src_i == MY_IDX);
    assign leader_drv = (phase_i == PH_UP) && is_src;
    assign top_drv    = (phase_i == PH_DOWN);
    assign row_drv_o  = (phase_i == PH_ACROSS) && is_src;

    always_comb begin
        col_bus = '0;
        if (leader_drv) col_bus = col_bus | word_i;
        if (top_drv)    col_bus = col_bus | top_q_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q_o    <= '0;
            leader_q_o <= '0;
        end else begin
            if (leader_drv)
                top_q_o <= col_bus;
            else if (phase_i == PH_ACROSS)
                top_q_o <= row_bus_i;
            if (phase_i == PH_DOWN)
                leader_q_o <= col_bus;
        end
    end

    // R6: the column bus carries one driver at most
    assert_column_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({leader_drv, top_drv}));
endmodule

// File: rtl/row_bus.sv
module row_bus #(
    parameter int NSUB = 4,
    parameter int DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSUB-1:0]   drv_en_i,
    input  logic [NSUB*DW-1:0] drv_data_i,
    output logic [DW-1:0]     bus_o
);
    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NSUB; i++) begin
            if (drv_en_i[i]) bus_o = bus_o | drv_data_i[i*DW +: DW];
        end
    end

    // R6: the shared row bus has one driving top-row processor at most
    assert_row_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_en_i));
endmodule

// File: rtl/row_leader_relay.sv
module row_leader_relay
    import relay_pkg::*;
#(
    parameter int NSUB = 4,
    parameter int DW   = 16,
    parameter int SELW = $clog2(NSUB) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [SELW-1:0]    src_sel_i,
    input  logic [DW-1:0]      data_i,
    output logic [NSUB*DW-1:0] leader_q_o,
    output logic               done_o
);
    phase_t             phase;
    logic [SELW-1:0]    src_q;
    logic [DW-1:0]      word_q;
    logic [DW-1:0]      row_bus_val;
    logic [NSUB-1:0]    row_drv;
    logic [NSUB*DW-1:0] top_q;

    relay_fsm #(.NSUB(NSUB), .DW(DW), .SELW(SELW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .src_sel_i (src_sel_i),
        .data_i    (data_i),
        .phase_o   (phase),
        .src_q_o   (src_q),
        .word_q_o  (word_q),
        .done_o    (done_o)
    );

    row_bus #(.NSUB(NSUB), .DW(DW)) u_row_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .drv_en_i   (row_drv),
        .drv_data_i (top_q),
        .bus_o      (row_bus_val)
    );

    for (genvar g = 0; g < NSUB; g++) begin : g_sub
        submesh_column #(.DW(DW), .SELW(SELW), .IDX(g)) u_col (
            .clk        (clk),
            .rst_n      (rst_n),
            .phase_i    (phase),
            .src_i      (src_q),
            .word_i     (word_q),
            .row_bus_i  (row_bus_val),
            .row_drv_o  (row_drv[g]),
            .top_q_o    (top_q[g*DW +: DW]),
            .leader_q_o (leader_q_o[g*DW +: DW])
        );
    end

    // R2: done is a single-cycle pulse
    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R7: leaders change only on the edge that closes the down phase
    assert_leader_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(leader_q_o) |-> ($past(phase) == PH_DOWN));
    // R2: done follows directly after the down phase
    assert_done_after_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(phase) == PH_DOWN));
endmodule

// File: tb/row_leader_relay_tb_top.sv
module row_leader_relay_tb_top;
    localparam int NSUB = 4;
    localparam int DW   = 16;
    localparam int SELW = $clog2(NSUB) + 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [SELW-1:0]    src = '0;
    logic [DW-1:0]      din = '0;
    logic [NSUB*DW-1:0] leaders;
    logic               done;

    always #10 clk = ~clk;

    row_leader_relay #(.NSUB(NSUB), .DW(DW), .SELW(SELW)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .src_sel_i  (src),
        .data_i     (din),
        .leader_q_o (leaders),
        .done_o     (done)
    );

    typedef struct {
        logic [DW-1:0] word;
        int            due;
    } exp_t;

    exp_t sb[$];
    exp_t cur;
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    int   n_done = 0;
    logic prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [SELW-1:0] s, input logic [DW-1:0] d);
        exp_t e;
        @(posedge clk); #1;
        src = s; din = d; start = 1'b1;
        e.word = d;
        e.due  = cyc + 4;
        sb.push_back(e);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic leaders_are(input logic [DW-1:0] w, input string req);
        for (int i = 0; i < NSUB; i++)
            chk(leaders[i*DW +: DW] == w, req, int'(leaders[i*DW +: DW]), int'(w));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                n_done++;
                chk(!prev_done, "R2 done pulse width", 1, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R4 R5 unexpected done", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    chk(cyc == cur.due, "R2 R8 latency", cyc, cur.due);
                    for (int i = 0; i < NSUB; i++)
                        chk(leaders[i*DW +: DW] == cur.word, "R3 leader word",
                            int'(leaders[i*DW +: DW]), int'(cur.word));
                end
            end
            prev_done <= done;
        end
    end

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        leaders_are('0, "R1 reset leaders");
        chk(done == 1'b0, "R1 reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        leaders_are('0, "R1 after release");

        // first, last and middle sources
        send(0, 16'h1234); repeat (5) @(posedge clk);
        send(3, 16'hFFFF); repeat (5) @(posedge clk);
        send(1, 16'h0000); repeat (5) @(posedge clk);

        // R7: old value held through the up and across phases
        send(2, 16'hA5A5);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(leaders[0 +: DW] == 16'h0000, "R7 hold before down",
                int'(leaders[0 +: DW]), 0);
        end
        repeat (5) @(posedge clk);

        // R4: start while busy
        send(1, 16'h5A5A);
        src = 0; din = 16'hDEAD; start = 1'b1;
        repeat (2) @(posedge clk); #1;
        start = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        leaders_are(16'h5A5A, "R4 busy start ignored");

        // R4: start during the done cycle
        send(2, 16'h0F0F);
        repeat (3) @(posedge clk); #1;
        src = 3; din = 16'hBEEF; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        leaders_are(16'h0F0F, "R4 done-cycle start ignored");

        // R5: out-of-range source
        @(posedge clk); #1;
        src = 3'd5; din = 16'h7777; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (6) @(posedge clk);
        @(negedge clk);
        leaders_are(16'h0F0F, "R5 bad source ignored");
        chk(n_done == 6, "R5 no done for bad source", n_done, 6);

        send(3, 16'hC3C3); repeat (6) @(posedge clk);
        @(negedge clk);
        chk(sb.size() == 0, "R2 missing done", sb.size(), 0);
        chk(n_done == 7, "R4 done count", n_done, 7);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule